// File: doc/BRIEF.md
# Text-Mode Video Character Generator

This block turns a screen of character codes into a serial monochrome pixel stream for a 40-column by 25-row text display. It also produces the composite sync timing and an active-window flag for a progressive frame. A 1000-entry character memory holds one code per cell. A 2048-byte font memory holds eight one-byte rows per glyph. Both memories have plain write ports, so they can be loaded at run time.

Each pixel lasts two system clocks, so a 16 MHz system clock gives an 8 MHz pixel rate. A line is 1024 pixel positions long. The frame has 262 lines when `palMode` is low and 312 lines when it is high. Each frame line carries one glyph row, so a text row spans eight consecutive lines. For each character, the glyph row byte is fetched ahead of time, loaded in parallel into a shifter, and sent out MSB first.

Two font modes exist. In the full mode every one of the 256 codes has its own glyph. In the reduced mode only 128 glyphs exist, and codes with bit 7 set show the glyph of the same low seven bits with every pixel inverted. A bank register supplies bit 7 of each newly written character, so the host writes only seven data bits.

Top module: `textvid_gen`

## Requirements
- R1: While `rst` is high, `syncN` is 0, `pixelOut` is 0 and `activeOut` is 0. The first system clock after release is pixel position 0 of line 0.
- R2: Every pixel position lasts exactly two system clocks. Position p of the stream is present during system clocks 2p and 2p+1 after reset release. A line has LINE_PCLKS positions.
- R3: `activeOut` is 1 exactly for positions H_START to H_START+8*COLS-1 on lines V_START to V_START+8*ROWS-1. `pixelOut` is 0 whenever `activeOut` is 0.
- R4: In full mode (mode register 0), pixel x of the window on window line y shows bit (7 - x mod 8) of font byte code*8 + (y mod 8). The code comes from character cell (y div 8)*COLS + (x div 8). The MSB is sent first.
- R5: In reduced mode (mode register 1), a code below 128 shows font byte code*8+row unchanged. A code of 128 or more shows font byte (code-128)*8+row with all bits inverted.
- R6: A character write stores {bank, charWrData[6:0]}, where bank is the bank register value (1 = upper half) at the time of the write. `ctrlWe` loads the mode register from `ctrlAlt` and the bank register from `ctrlUpper`. Both registers reset to 0.
- R7: `syncN` is 0 on positions 0 to HSYNC_LEN-1 of every line.
- R8: `syncN` is 0 for the whole of lines 0 to VSYNC_LINES-1. The frame has NTSC_LINES lines with `palMode`=0 and PAL_LINES lines with `palMode`=1.
- R9: A font write made while the display runs changes the pixels of the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| palMode | input | 1 | 0 selects the short frame, 1 the long frame |
| ctrlWe | input | 1 | Load the mode and bank registers |
| ctrlAlt | input | 1 | Mode value: 0 full 256-glyph set, 1 reduced set with inverse |
| ctrlUpper | input | 1 | Bank value: 1 selects the upper code half |
| charWe | input | 1 | Character memory write enable |
| charWrAddr | input | $clog2(COLS*ROWS) | Character cell address, row*COLS+col |
| charWrData | input | 7 | Low seven code bits |
| fontWe | input | 1 | Font memory write enable |
| fontWrAddr | input | 11 | Font byte address, code*8+row |
| fontWrData | input | 8 | Glyph row byte, bit 7 is the leftmost pixel |
| pixelOut | output | 1 | Serial pixel |
| syncN | output | 1 | Composite sync, active low |
| activeOut | output | 1 | High inside the visible window |

## Verification
On the tick that starts a character, the shifter must take a new glyph byte instead of shifting the old one. In that same cycle the previous character's last pixel leaves the output. The line and frame counters also wrap on one tick at the end of a frame. Whole frames are swept in a reduced configuration, and every system clock is compared against a pixel, window and sync value that the bench computes arithmetically from the clock count since reset. This exposes any off-by-one at character, line or frame boundaries. Mode, bank and font changes are made in vertical blanking, and the next frame is judged in the same way.

// File: rtl/textvid_pkg.sv
package textvid_pkg;
  localparam int GLYPH_ROWS = 8;
  localparam int GLYPH_COUNT = 256;
  localparam int FONT_DEPTH = GLYPH_ROWS * GLYPH_COUNT;
  localparam int FONT_AW = $clog2(FONT_DEPTH);

  typedef struct packed {
    logic tick;       // pixel position advances at this edge
    logic charRd;     // fetch character code
    logic fontRd;     // fetch glyph row byte
    logic load;       // parallel load of shifter
    logic activeNow;  // current position inside window
    logic syncNow;    // current position inside a sync pulse
  } vidStrobe_t;
endpackage

// File: rtl/textvid_ctrl.sv
module textvid_ctrl
  import textvid_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 25,
  parameter int LINE_PCLKS = 1024,
  parameter int H_START = 192,
  parameter int HSYNC_LEN = 76,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES = 312,
  parameter int V_START = 30,
  parameter int VSYNC_LINES = 3,
  localparam int CHARS = COLS * ROWS,
  localparam int CAW = $clog2(CHARS),
  localparam int HW = $clog2(LINE_PCLKS),
  localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
  localparam int VW = $clog2(MAX_LINES),
  localparam int ACT_W = 8 * COLS,
  localparam int ACT_H = GLYPH_ROWS * ROWS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           palMode,
  output vidStrobe_t     strb,
  output logic [HW-1:0]  hCnt,
  output logic [VW-1:0]  vCnt,
  output logic [CAW-1:0] charAddr,
  output logic [2:0]     glyphRow
);
  logic phase;
  int hPos, vPos, vRel, hAhead2, hAhead1, lastLine;
  logic lineOn, fetchSlot;

  always_comb begin
    hPos = int'(hCnt);
    vPos = int'(vCnt);
    vRel = vPos - V_START;
    hAhead2 = hPos + 2 - H_START;
    hAhead1 = hPos + 1 - H_START;
    lastLine = palMode ? PAL_LINES - 1 : NTSC_LINES - 1;
    lineOn = (vRel >= 0) && (vRel < ACT_H);
    fetchSlot = lineOn && (hAhead2 >= 0) && (hAhead2 < ACT_W) && ((hAhead2 % 8) == 0);
    strb.tick = phase;
    strb.charRd = !phase && fetchSlot;
    strb.fontRd = phase && fetchSlot;
    strb.load = phase && lineOn && (hAhead1 >= 0) && (hAhead1 < ACT_W) && ((hAhead1 % 8) == 0);
    strb.activeNow = lineOn && (hPos >= H_START) && (hPos < H_START + ACT_W);
    strb.syncNow = (hPos < HSYNC_LEN) || (vPos < VSYNC_LINES);
    if (fetchSlot) begin
      charAddr = CAW'((vRel / GLYPH_ROWS) * COLS + hAhead2 / 8);
      glyphRow = 3'(vRel % GLYPH_ROWS);
    end else begin
      charAddr = '0;
      glyphRow = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (hPos == LINE_PCLKS - 1) begin
          hCnt <= '0;
          if (vPos >= lastLine) vCnt <= '0;
          else vCnt <= vCnt + VW'(1);
        end else begin
          hCnt <= hCnt + HW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/textvid_datapath.sv
module textvid_datapath
  import textvid_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 25,
  localparam int CHARS = COLS * ROWS,
  localparam int CAW = $clog2(CHARS)
) (
  input  logic               clk,
  input  logic               rst,
  input  vidStrobe_t         strb,
  input  logic [CAW-1:0]     rdAddr,
  input  logic [2:0]         glyphRow,
  input  logic               ctrlWe,
  input  logic               ctrlAlt,
  input  logic               ctrlUpper,
  input  logic               charWe,
  input  logic [CAW-1:0]     charWrAddr,
  input  logic [6:0]         charWrData,
  input  logic               fontWe,
  input  logic [FONT_AW-1:0] fontWrAddr,
  input  logic [7:0]         fontWrData,
  output logic               pixelOut,
  output logic               syncN,
  output logic               activeOut
);
  logic [7:0] charMem [CHARS];
  logic [7:0] fontMem [FONT_DEPTH];
  logic altMode, upperBank;
  logic [7:0] charCode, fontRow, shiftReg, glyphSel;
  logic invRow, invNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      altMode <= 1'b0;
      upperBank <= 1'b0;
    end else if (ctrlWe) begin
      altMode <= ctrlAlt;
      upperBank <= ctrlUpper;
    end
  end

  always_ff @(posedge clk) begin
    if (charWe && (int'(charWrAddr) < CHARS)) charMem[charWrAddr] <= {upperBank, charWrData};
    if (fontWe) fontMem[fontWrAddr] <= fontWrData;
  end

  // reduced mode folds the upper half onto the lower glyphs, inverted
  always_comb begin
    glyphSel = altMode ? {1'b0, charCode[6:0]} : charCode;
    invNow = altMode & charCode[7];
  end

  always_ff @(posedge clk) begin
    if (strb.charRd) charCode <= charMem[rdAddr];
    if (strb.fontRd) begin
      fontRow <= fontMem[{glyphSel, glyphRow}];
      invRow <= invNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (strb.load) shiftReg <= fontRow ^ {8{invRow}};
    else if (strb.tick) shiftReg <= {shiftReg[6:0], 1'b0};
  end

  assign pixelOut = shiftReg[7];
  assign syncN = ~strb.syncNow;
  assign activeOut = strb.activeNow;
endmodule

// File: rtl/textvid_gen.sv
module textvid_gen
  import textvid_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 25,
  parameter int LINE_PCLKS = 1024,
  parameter int H_START = 192,
  parameter int HSYNC_LEN = 76,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES = 312,
  parameter int V_START = 30,
  parameter int VSYNC_LINES = 3,
  localparam int CAW = $clog2(COLS * ROWS),
  localparam int HW = $clog2(LINE_PCLKS),
  localparam int VW = $clog2((PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               palMode,
  input  logic               ctrlWe,
  input  logic               ctrlAlt,
  input  logic               ctrlUpper,
  input  logic               charWe,
  input  logic [CAW-1:0]     charWrAddr,
  input  logic [6:0]         charWrData,
  input  logic               fontWe,
  input  logic [FONT_AW-1:0] fontWrAddr,
  input  logic [7:0]         fontWrData,
  output logic               pixelOut,
  output logic               syncN,
  output logic               activeOut
);
  vidStrobe_t strb;
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic [CAW-1:0] rdAddr;
  logic [2:0] glyphRow;

  textvid_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .LINE_PCLKS(LINE_PCLKS), .H_START(H_START),
    .HSYNC_LEN(HSYNC_LEN), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .V_START(V_START), .VSYNC_LINES(VSYNC_LINES)
  ) ctrlInst (
    .clk(clk), .rst(rst), .palMode(palMode), .strb(strb),
    .hCnt(hCnt), .vCnt(vCnt), .charAddr(rdAddr), .glyphRow(glyphRow)
  );

  textvid_datapath #(.COLS(COLS), .ROWS(ROWS)) dpInst (
    .clk(clk), .rst(rst), .strb(strb), .rdAddr(rdAddr), .glyphRow(glyphRow),
    .ctrlWe(ctrlWe), .ctrlAlt(ctrlAlt), .ctrlUpper(ctrlUpper),
    .charWe(charWe), .charWrAddr(charWrAddr), .charWrData(charWrData),
    .fontWe(fontWe), .fontWrAddr(fontWrAddr), .fontWrData(fontWrData),
    .pixelOut(pixelOut), .syncN(syncN), .activeOut(activeOut)
  );
endmodule

// File: rtl/textvid_gen_checker.sv
module textvid_gen_checker #(
  parameter int LINE_PCLKS = 1024,
  parameter int HSYNC_LEN = 76,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES = 312,
  parameter int V_START = 30,
  parameter int ROWS = 25,
  parameter int HW = 10,
  parameter int VW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          palMode,
  input logic [HW-1:0] hCnt,
  input logic [VW-1:0] vCnt,
  input logic          pixelOut,
  input logic          syncN,
  input logic          activeOut
);
  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pixelOut) && $stable(syncN) && $stable(activeOut)));

  // R3
  dark_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !activeOut |-> !pixelOut);

  // R3
  window_rows_chk: assert property (@(posedge clk) disable iff (rst)
    activeOut |-> ((int'(vCnt) >= V_START) && (int'(vCnt) < V_START + 8 * ROWS)));

  // R7
  hsync_low_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(hCnt) < HSYNC_LEN) |-> !syncN);

  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && int'(hCnt) == LINE_PCLKS - 1 && $stable(palMode) &&
     int'(vCnt) == (palMode ? PAL_LINES - 1 : NTSC_LINES - 1)) |=> (vCnt == '0));

  // R8
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(vCnt) < ((PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES));
endmodule

bind textvid_gen textvid_gen_checker #(
  .LINE_PCLKS(LINE_PCLKS), .HSYNC_LEN(HSYNC_LEN), .NTSC_LINES(NTSC_LINES),
  .PAL_LINES(PAL_LINES), .V_START(V_START), .ROWS(ROWS), .HW(HW), .VW(VW)
) checkInst (
  .clk(clk), .rst(rst), .tick(strb.tick), .palMode(palMode), .hCnt(hCnt), .vCnt(vCnt),
  .pixelOut(pixelOut), .syncN(syncN), .activeOut(activeOut)
);

// File: tb/textvid_gen_test.sv
`timescale 1ns/1ps
module textvid_gen_test;
  localparam int COLS = 4, ROWS = 2, LINE = 64, HS = 16, HSYNC = 6;
  localparam int NL = 24, PL = 28, VS = 4, VSYNC = 2;
  localparam int CELLS = COLS * ROWS;
  localparam int CAW = $clog2(CELLS);

  logic clk = 1'b0, rst = 1'b1, palMode = 1'b0;
  logic ctrlWe = 0, ctrlAlt = 0, ctrlUpper = 0, charWe = 0, fontWe = 0;
  logic [CAW-1:0] charWrAddr = '0;
  logic [6:0] charWrData = '0;
  logic [10:0] fontWrAddr = '0;
  logic [7:0] fontWrData = '0;
  logic pixelOut, syncN, activeOut;

  always #2.5 clk = ~clk;

  textvid_gen #(
    .COLS(COLS), .ROWS(ROWS), .LINE_PCLKS(LINE), .H_START(HS), .HSYNC_LEN(HSYNC),
    .NTSC_LINES(NL), .PAL_LINES(PL), .V_START(VS), .VSYNC_LINES(VSYNC)
  ) uut (.*);

  int compared = 0, mismatched = 0, e = 0, rstCyc = 0, lines = NL;
  logic checkEn = 0, modelAlt = 0, bankModel = 0;
  logic [7:0] charModel [CELLS];
  logic [7:0] fontModel [2048];
  string segTag = "R4";

  always @(posedge clk) if (rst) e <= 0; else e <= e + 1;

  function automatic logic [7:0] fontVal(int i);
    return 8'((i * 29 + (i >> 3) * 7 + 3) ^ (i >> 5));
  endfunction

  function automatic logic expActive(int h, int v);
    return (h >= HS) && (h < HS + 8 * COLS) && (v >= VS) && (v < VS + 8 * ROWS);
  endfunction

  function automatic logic expPixel(int h, int v);
    int x, y, idx;
    logic [7:0] code, row;
    logic inv;
    if (!expActive(h, v)) return 1'b0;
    x = h - HS; y = v - VS;
    code = charModel[(y / 8) * COLS + x / 8];
    if (modelAlt) begin idx = int'(code[6:0]); inv = code[7]; end
    else begin idx = int'(code); inv = 1'b0; end
    row = fontModel[idx * 8 + y % 8];
    return row[7 - x % 8] ^ inv;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b (clock %0d)", tag, what, act, exp, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rstCyc++;
      if (rstCyc > 2) begin
        check("R1", syncN, 1'b0, "sync in reset");
        check("R1", pixelOut, 1'b0, "pixel in reset");
        check("R1", activeOut, 1'b0, "active in reset");
      end
    end else if (checkEn) begin
      int pos, h, v;
      pos = e / 2; h = pos % LINE; v = (pos / LINE) % lines;
      check((e % 2) ? "R2" : "R3", activeOut, expActive(h, v), "window");
      check((v < VSYNC) ? "R8" : "R7", syncN, !((h < HSYNC) || (v < VSYNC)), "sync");
      check(expActive(h, v) ? segTag : "R3", pixelOut, expPixel(h, v), "pixel");
    end
  end

  task automatic waitUntil(int target);
    while (e < target) @(negedge clk);
  endtask

  task automatic writeChar(int a, int d);
    @(negedge clk);
    charWe = 1; charWrAddr = CAW'(a); charWrData = 7'(d);
    charModel[a] = {bankModel, 7'(d)};
    @(negedge clk);
    charWe = 0;
  endtask

  task automatic writeFont(int a, logic [7:0] d);
    @(negedge clk);
    fontWe = 1; fontWrAddr = 11'(a); fontWrData = d;
    fontModel[a] = d;
    @(negedge clk);
    fontWe = 0;
  endtask

  task automatic setCtrl(logic alt, logic upper);
    @(negedge clk);
    ctrlWe = 1; ctrlAlt = alt; ctrlUpper = upper;
    @(negedge clk);
    ctrlWe = 0; modelAlt = alt; bankModel = upper;
  endtask

  function automatic int frameLine(int frame, int line);
    return 2 * (frame * lines * LINE + line * LINE);
  endfunction

  initial begin
    // preload while in reset; R1 checks run alongside
    for (int i = 0; i < 2048; i++) writeFont(i, fontVal(i));
    for (int c = 0; c < CELLS; c++) writeChar(c, 7'h21 + 13 * c);
    @(negedge clk);
    rst = 0; checkEn = 1; segTag = "R4";
    waitUntil(frameLine(1, 1));
    // R6: upper bank for the next writes, full mode
    setCtrl(1'b0, 1'b1);
    segTag = "R6";
    for (int c = 0; c < 4; c++) writeChar(c, 7'h05 + 9 * c);
    waitUntil(frameLine(2, 1));
    // R5: reduced mode, some cells above 127
    setCtrl(1'b1, 1'b1);
    writeChar(5, 7'h33);
    segTag = "R5";
    waitUntil(frameLine(3, 1));
    // R9: rewrite the glyph rows of cell 7 and cell 0 at run time
    for (int r = 0; r < 8; r++) writeFont(int'(charModel[7][6:0]) * 8 + r, ~fontModel[int'(charModel[7][6:0]) * 8 + r]);
    for (int r = 0; r < 8; r++) writeFont(int'(charModel[0][6:0]) * 8 + r, 8'(8'hA5 >> (r % 3)));
    segTag = "R9";
    waitUntil(frameLine(4, 0));
    // R8: long frame after a fresh reset
    @(negedge clk);
    checkEn = 0; rst = 1; palMode = 1; rstCyc = 0;
    modelAlt = 0; bankModel = 0;
    repeat (6) @(negedge clk);
    lines = PL;
    rst = 0; checkEn = 1; segTag = "R4";
    waitUntil(frameLine(2, 2));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule